// File: doc/BRIEF.md
# Memory Command Scheduler with Two Service Classes

The scheduler holds a small queue of pending memory reads and writes and, every cycle in which the downstream SDRAM controller can take a command, names the queue slot that should go next. Each queued command carries its master ID, a priority (0 is the most urgent), a read or write flag, the 2048-byte block and the bank taken from its byte address, its service class and its waiting time. The controller raises `issue_en` when it can accept a command. The scheduler answers in the same cycle with `issue_valid` and `issue_idx`. The chosen slot leaves the queue at the next clock edge.

The queue is kept in arrival order. Slot 0 always holds the oldest command, and the younger slots close up when a command leaves. Reads may pass older writes only where that is safe. Commands whose bank is already open are preferred. Priority, then age, picks a read candidate and a write candidate, and a run-length threshold chooses between them. A class is fixed when a command enters the queue, from a master-ID match or from a per-priority map. Each class has a latency limit, and a command that has waited that long goes ahead of the normal order.

Top module: `cmd_sched`

## Requirements
- R1: A read is eligible only if no older queued write from the same master has a numerically lower (more urgent) priority value. Equal priority, or a read that is more urgent, may pass the write.
- R2: A read is not eligible while any older queued write, from any master, targets the same block. The block is byte address bits [ADDR_W-1:BLK_LSB].
- R3: The bank is address bits [BANK_LSB+BANK_W-1:BANK_LSB], looked up in `bank_open`. If some eligible read has an open bank, only reads with open banks compete. The same rule applies separately to writes.
- R4: Among the competing reads, and separately among the competing writes, the lowest priority value wins. On a tie the lower slot index wins. Slot 0 is the oldest entry, and entries close up in arrival order after every issue.
- R5: When both a read and a write candidate exist, the scheduler keeps the direction of the previous issue while its count of consecutive issues is below `cfg_rw_thresh`, and switches direction otherwise. After reset the previous direction is read and the count is zero.
- R6: A command's class is `cfg_pri_cls[priority]` unless the master-ID rule applies. A command whose age is at or above its class limit (`cfg_lat0` or `cfg_lat1`) is issued before all non-expired commands.
- R7: The master-ID rule applies when `cfg_mid_en` is 1 and ((master XOR `cfg_mid_match`) AND `cfg_mid_mask`) is zero. It then sets the class to `cfg_mid_cls`, overriding the priority map.
- R8: If slot 0 holds an expired eligible command, slot 0 issues, whatever the priorities of the others.
- R9: If several eligible commands are expired and slot 0 is not one of them, the lowest priority value issues, with the lower slot index winning ties.
- R10: Age is 0 in the cycle after enqueue, rises by one per clock while queued, and saturates at 2^LAT_W-1.
- R11: `issue_valid` is 1 only when `issue_en` is 1 and an eligible command is queued. An enqueue is accepted when the queue is not full, or when a command issues in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue a command this cycle |
| enq_mid | input | MID_W | Master ID |
| enq_pri | input | PRI_W | Priority, 0 most urgent |
| enq_wr | input | 1 | 1 write, 0 read |
| enq_addr | input | ADDR_W | Byte address |
| bank_open | input | 2^BANK_W | Per-bank open-row flag |
| cfg_pri_cls | input | 2^PRI_W | Class for each priority value |
| cfg_mid_en | input | 1 | Enable the master-ID class rule |
| cfg_mid_match | input | MID_W | Master-ID compare value |
| cfg_mid_mask | input | MID_W | Master-ID compare mask |
| cfg_mid_cls | input | 1 | Class given on a master-ID match |
| cfg_lat0 | input | LAT_W | Latency limit of class 0 |
| cfg_lat1 | input | LAT_W | Latency limit of class 1 |
| cfg_rw_thresh | input | THR_W | Consecutive-issue threshold for direction switch |
| issue_en | input | 1 | Controller accepts a command this cycle |
| issue_valid | output | 1 | A command issues this cycle |
| issue_idx | output | $clog2(DEPTH) | Slot index of the issuing command |

## Verification
The bench builds the block with DEPTH=6, a 16-bit address, 2048-byte blocks whose two lowest block bits select one of four banks, LAT_W=5 and THR_W=3. Six slots leave room for three reads ahead of two writes, so a threshold of 2 shows a full run in each direction and a switch back. A 5-bit age saturates at 31 within a 40-cycle wait, so saturation can be told apart from wrap-around. Small latency limits of 2 set expired and non-expired commands side by side in one queue.

// File: rtl/cmd_sched_pkg.sv
package cmd_sched_pkg;
   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } dir_e;
endpackage

// File: rtl/cmd_sched_queue.sv
module cmd_sched_queue #(
   parameter int DEPTH = 8,
   parameter int MID_W = 4,
   parameter int PRI_W = 3,
   parameter int BLK_W = 21,
   parameter int BANK_W = 3,
   parameter int LAT_W = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            push,
   input  logic [MID_W-1:0]                push_mid,
   input  logic [PRI_W-1:0]                push_pri,
   input  logic                            push_wr,
   input  logic [BLK_W-1:0]                push_blk,
   input  logic [BANK_W-1:0]               push_bank,
   input  logic                            push_cls,
   input  logic                            pop,
   input  logic [IDX_W-1:0]                pop_idx,
   output logic [DEPTH-1:0]                q_valid,
   output logic [DEPTH-1:0][MID_W-1:0]     q_mid,
   output logic [DEPTH-1:0][PRI_W-1:0]     q_pri,
   output logic [DEPTH-1:0]                q_wr,
   output logic [DEPTH-1:0][BLK_W-1:0]     q_blk,
   output logic [DEPTH-1:0][BANK_W-1:0]    q_bank,
   output logic [DEPTH-1:0]                q_cls,
   output logic [DEPTH-1:0][LAT_W-1:0]     q_age
);
   localparam logic [LAT_W-1:0] AGE_MAX = '1;

   logic [DEPTH-1:0]             n_valid, n_wr, n_cls;
   logic [DEPTH-1:0][MID_W-1:0]  n_mid;
   logic [DEPTH-1:0][PRI_W-1:0]  n_pri;
   logic [DEPTH-1:0][BLK_W-1:0]  n_blk;
   logic [DEPTH-1:0][BANK_W-1:0] n_bank;
   logic [DEPTH-1:0][LAT_W-1:0]  n_age;
   int                           wpos;

   always_comb begin
      n_valid = '0; n_wr = '0; n_cls = '0; n_mid = '0;
      n_pri = '0; n_blk = '0; n_bank = '0; n_age = '0;
      for (int i = 0; i < DEPTH; i++) begin
         int src;
         src = (pop && i >= int'(pop_idx)) ? i + 1 : i;
         if (src < DEPTH) begin
            n_valid[i] = q_valid[src];
            n_wr[i]    = q_wr[src];
            n_cls[i]   = q_cls[src];
            n_mid[i]   = q_mid[src];
            n_pri[i]   = q_pri[src];
            n_blk[i]   = q_blk[src];
            n_bank[i]  = q_bank[src];
            n_age[i]   = (q_age[src] == AGE_MAX) ? AGE_MAX : q_age[src] + 1'b1;
         end
      end
      wpos = $countones(q_valid) - (pop ? 1 : 0);
      if (push && wpos < DEPTH) begin
         n_valid[wpos] = 1'b1;
         n_wr[wpos]    = push_wr;
         n_cls[wpos]   = push_cls;
         n_mid[wpos]   = push_mid;
         n_pri[wpos]   = push_pri;
         n_blk[wpos]   = push_blk;
         n_bank[wpos]  = push_bank;
         n_age[wpos]   = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= '0; q_wr <= '0; q_cls <= '0; q_mid <= '0;
         q_pri <= '0; q_blk <= '0; q_bank <= '0; q_age <= '0;
      end else begin
         q_valid <= n_valid; q_wr <= n_wr; q_cls <= n_cls; q_mid <= n_mid;
         q_pri <= n_pri; q_blk <= n_blk; q_bank <= n_bank; q_age <= n_age;
      end
   end

   AST_AGE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid[0] && !pop) |=> (q_age[0] >= $past(q_age[0]))); // R10

   AST_POP_HELD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> q_valid[pop_idx]); // R11
endmodule

// File: rtl/cmd_sched_pick.sv
module cmd_sched_pick #(
   parameter int DEPTH = 8,
   parameter int PRI_W = 3,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]             cand,
   input  logic [DEPTH-1:0]             pref,
   input  logic [DEPTH-1:0][PRI_W-1:0]  pri,
   output logic                         found,
   output logic [IDX_W-1:0]             idx
);
   logic [DEPTH-1:0] pool;
   logic [PRI_W-1:0] best;

   always_comb begin
      pool  = (|(cand & pref)) ? (cand & pref) : cand;
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (pool[i] && (!found || pri[i] < best)) begin
            found = 1'b1;
            idx   = IDX_W'(i);
            best  = pri[i];
         end
      end
   end
endmodule

// File: rtl/cmd_sched.sv
module cmd_sched
   import cmd_sched_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int MID_W = 4,
   parameter int PRI_W = 3,
   parameter int ADDR_W = 32,
   parameter int BLK_LSB = 11,
   parameter int BANK_LSB = 11,
   parameter int BANK_W = 3,
   parameter int LAT_W = 8,
   parameter int THR_W = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int NPRI = 1 << PRI_W,
   localparam int NBANK = 1 << BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [MID_W-1:0]  enq_mid,
   input  logic [PRI_W-1:0]  enq_pri,
   input  logic              enq_wr,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic [NBANK-1:0]  bank_open,
   input  logic [NPRI-1:0]   cfg_pri_cls,
   input  logic              cfg_mid_en,
   input  logic [MID_W-1:0]  cfg_mid_match,
   input  logic [MID_W-1:0]  cfg_mid_mask,
   input  logic              cfg_mid_cls,
   input  logic [LAT_W-1:0]  cfg_lat0,
   input  logic [LAT_W-1:0]  cfg_lat1,
   input  logic [THR_W-1:0]  cfg_rw_thresh,
   input  logic              issue_en,
   output logic              issue_valid,
   output logic [IDX_W-1:0]  issue_idx
);
   localparam int BLK_W = ADDR_W - BLK_LSB;
   localparam int LOW_BITS = (BLK_LSB < BANK_LSB) ? BLK_LSB : BANK_LSB;
   localparam logic [THR_W-1:0] RUN_MAX = '1;

   if (DEPTH < 2) begin : g_chk_depth
      $error("cmd_sched: DEPTH must be at least 2");
   end
   if (BLK_LSB >= ADDR_W || BANK_LSB + BANK_W > ADDR_W) begin : g_chk_addr
      $error("cmd_sched: block or bank field outside the address");
   end

   if (LOW_BITS > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^enq_addr[LOW_BITS-1:0];
   end

   logic [DEPTH-1:0]             q_valid, q_wr, q_cls;
   logic [DEPTH-1:0][MID_W-1:0]  q_mid;
   logic [DEPTH-1:0][PRI_W-1:0]  q_pri;
   logic [DEPTH-1:0][BLK_W-1:0]  q_blk;
   logic [DEPTH-1:0][BANK_W-1:0] q_bank;
   logic [DEPTH-1:0][LAT_W-1:0]  q_age;

   logic mid_hit, push_cls;
   assign mid_hit  = cfg_mid_en && (((enq_mid ^ cfg_mid_match) & cfg_mid_mask) == '0);
   assign push_cls = mid_hit ? cfg_mid_cls : cfg_pri_cls[enq_pri];

   cmd_sched_queue #(
      .DEPTH(DEPTH), .MID_W(MID_W), .PRI_W(PRI_W),
      .BLK_W(BLK_W), .BANK_W(BANK_W), .LAT_W(LAT_W)
   ) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(enq_valid), .push_mid(enq_mid), .push_pri(enq_pri), .push_wr(enq_wr),
      .push_blk(enq_addr[ADDR_W-1:BLK_LSB]), .push_bank(enq_addr[BANK_LSB +: BANK_W]),
      .push_cls(push_cls), .pop(issue_valid), .pop_idx(issue_idx),
      .q_valid(q_valid), .q_mid(q_mid), .q_pri(q_pri), .q_wr(q_wr),
      .q_blk(q_blk), .q_bank(q_bank), .q_cls(q_cls), .q_age(q_age)
   );

   logic [DEPTH-1:0] rd_ok, wr_ok, open_b, expired;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic hazard;
      always_comb begin
         hazard = 1'b0;
         for (int j = 0; j < i; j++) begin
            if (q_valid[j] && q_wr[j] &&
                (q_blk[j] == q_blk[i] ||
                 (q_mid[j] == q_mid[i] && q_pri[i] > q_pri[j])))
               hazard = 1'b1;
         end
      end
      assign rd_ok[i]   = q_valid[i] && !q_wr[i] && !hazard;
      assign wr_ok[i]   = q_valid[i] && q_wr[i];
      assign open_b[i]  = bank_open[q_bank[i]];
      assign expired[i] = (rd_ok[i] || wr_ok[i]) &&
                          (q_age[i] >= (q_cls[i] ? cfg_lat1 : cfg_lat0));
   end

   logic             rd_found, wr_found, ex_found;
   logic [IDX_W-1:0] rd_idx, wr_idx, ex_idx;

   cmd_sched_pick #(.DEPTH(DEPTH), .PRI_W(PRI_W)) u_pick_rd (
      .cand(rd_ok), .pref(open_b), .pri(q_pri), .found(rd_found), .idx(rd_idx));
   cmd_sched_pick #(.DEPTH(DEPTH), .PRI_W(PRI_W)) u_pick_wr (
      .cand(wr_ok), .pref(open_b), .pri(q_pri), .found(wr_found), .idx(wr_idx));
   cmd_sched_pick #(.DEPTH(DEPTH), .PRI_W(PRI_W)) u_pick_ex (
      .cand(expired), .pref(DEPTH'(1)), .pri(q_pri), .found(ex_found), .idx(ex_idx));

   dir_e             last_dir;
   logic [THR_W-1:0] run_cnt;
   logic             sel_found;
   logic [IDX_W-1:0] sel_idx;
   dir_e             sel_dir;

   always_comb begin
      sel_found = ex_found || rd_found || wr_found;
      if (ex_found)
         sel_idx = ex_idx;
      else if (rd_found && wr_found)
         sel_idx = ((run_cnt >= cfg_rw_thresh) ^ (last_dir == DIR_WR)) ? wr_idx : rd_idx;
      else if (wr_found)
         sel_idx = wr_idx;
      else
         sel_idx = rd_idx;
      sel_dir = q_wr[sel_idx] ? DIR_WR : DIR_RD;
   end

   assign issue_valid = issue_en && sel_found;
   assign issue_idx   = sel_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_dir <= DIR_RD;
         run_cnt  <= '0;
      end else if (issue_valid) begin
         last_dir <= sel_dir;
         if (sel_dir != last_dir)
            run_cnt <= THR_W'(1);
         else if (run_cnt != RUN_MAX)
            run_cnt <= run_cnt + 1'b1;
      end
   end

   AST_OLDEST_EXPIRED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && expired[0]) |-> (issue_idx == '0)); // R8

   AST_RUN_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> (run_cnt != '0)); // R5

   AST_ISSUE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_en && q_valid[issue_idx])); // R11

   AST_DIR_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> (last_dir == $past(sel_dir))); // R5
endmodule

// File: tb/sim_cmd_sched.sv
module sim_cmd_sched;
   localparam int CLK_P = 10;
   localparam int DEPTH = 6;
   localparam int IDX_W = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enq_valid = 1'b0;
   logic [3:0]       enq_mid = '0;
   logic [2:0]       enq_pri = '0;
   logic             enq_wr = 1'b0;
   logic [15:0]      enq_addr = '0;
   logic [3:0]       bank_open = '1;
   logic [7:0]       cfg_pri_cls = '0;
   logic             cfg_mid_en = 1'b0;
   logic [3:0]       cfg_mid_match = '0;
   logic [3:0]       cfg_mid_mask = '0;
   logic             cfg_mid_cls = 1'b0;
   logic [4:0]       cfg_lat0 = 5'd31;
   logic [4:0]       cfg_lat1 = 5'd31;
   logic [2:0]       cfg_rw_thresh = 3'd4;
   logic             issue_en = 1'b0;
   logic             issue_valid;
   logic [IDX_W-1:0] issue_idx;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   int    exp_q[$];
   string tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   cmd_sched #(
      .DEPTH(DEPTH), .MID_W(4), .PRI_W(3), .ADDR_W(16), .BLK_LSB(11),
      .BANK_LSB(11), .BANK_W(2), .LAT_W(5), .THR_W(3)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_mid(enq_mid),
      .enq_pri(enq_pri), .enq_wr(enq_wr), .enq_addr(enq_addr), .bank_open(bank_open),
      .cfg_pri_cls(cfg_pri_cls), .cfg_mid_en(cfg_mid_en), .cfg_mid_match(cfg_mid_match),
      .cfg_mid_mask(cfg_mid_mask), .cfg_mid_cls(cfg_mid_cls), .cfg_lat0(cfg_lat0),
      .cfg_lat1(cfg_lat1), .cfg_rw_thresh(cfg_rw_thresh), .issue_en(issue_en),
      .issue_valid(issue_valid), .issue_idx(issue_idx)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the design issues
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (rst_n && issue_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R11 unexpected issue", int'(issue_idx), -1);
            end else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(int'(issue_idx) == e, t, int'(issue_idx), e);
            end
         end
      end
   end

   task automatic expect_idx(input int idx, input string tag);
      exp_q.push_back(idx);
      tag_q.push_back(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      issue_en = 1'b0;
      enq_valid = 1'b0;
      bank_open = '1;
      cfg_pri_cls = '0;
      cfg_mid_en = 1'b0;
      cfg_mid_match = '0;
      cfg_mid_mask = '0;
      cfg_mid_cls = 1'b0;
      cfg_lat0 = 5'd31;
      cfg_lat1 = 5'd31;
      cfg_rw_thresh = 3'd4;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic enq(input bit w, input int m, input int p, input int blk);
      enq_valid = 1'b1;
      enq_wr    = w;
      enq_mid   = 4'(m);
      enq_pri   = 3'(p);
      enq_addr  = 16'(blk << 11);
      @(negedge clk);
      enq_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run(input int n);
      issue_en = 1'b1;
      repeat (n) @(negedge clk);
      issue_en = 1'b0;
   endtask

   task automatic drain(input string tag);
      issue_en = 1'b1;
      repeat (2) @(negedge clk);
      issue_en = 1'b0;
      #(CLK_P/4);
      check(exp_q.size() == 0, tag, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
   endtask

   initial begin
      // reset state: empty queue, enable high, nothing issues
      do_reset();
      issue_en = 1'b1;
      #(CLK_P/4);
      check(issue_valid == 1'b0, "R11 empty after reset", int'(issue_valid), 0);
      @(negedge clk);
      issue_en = 1'b0;

      // R1: same-master read passes write only at equal or better priority
      do_reset();
      enq(1, 1, 3, 1);
      enq(0, 1, 3, 2);
      enq(0, 1, 5, 3);
      #(CLK_P/4);
      check(issue_valid == 1'b0, "R11 enable low holds", int'(issue_valid), 0);
      @(negedge clk);
      expect_idx(1, "R1 equal-priority read passes write");
      expect_idx(0, "R1 lower-priority read waits for write");
      expect_idx(0, "R1 last read");
      run(3);
      drain("R1 all issued");

      // R2: same-block hazard blocks reads from any master
      do_reset();
      enq(1, 1, 4, 5);
      enq(0, 2, 0, 5);
      enq(0, 2, 2, 6);
      expect_idx(2, "R2 read to other block goes first");
      expect_idx(0, "R2 write before same-block read");
      expect_idx(0, "R2 blocked read last");
      run(3);
      drain("R2 all issued");

      // R3: open-bank preference over priority
      do_reset();
      bank_open = 4'b0100;
      enq(0, 1, 0, 1);
      enq(0, 2, 6, 2);
      enq(0, 3, 1, 6);
      expect_idx(2, "R3 best open-bank read");
      expect_idx(1, "R3 remaining open-bank read");
      expect_idx(0, "R3 closed-bank read last");
      run(3);
      drain("R3 all issued");

      // R4: priority then oldest
      do_reset();
      enq(0, 1, 2, 1);
      enq(0, 2, 1, 2);
      enq(0, 3, 1, 3);
      expect_idx(1, "R4 oldest of tied priority");
      expect_idx(1, "R4 next tied after compaction");
      expect_idx(0, "R4 lowest priority last");
      run(3);
      drain("R4 all issued");

      // R5: read/write threshold of 2
      do_reset();
      cfg_rw_thresh = 3'd2;
      enq(0, 1, 0, 1);
      enq(0, 2, 0, 2);
      enq(0, 3, 0, 3);
      enq(1, 4, 0, 9);
      enq(1, 5, 0, 10);
      expect_idx(0, "R5 read run 1");
      expect_idx(0, "R5 read run 2");
      expect_idx(1, "R5 switch to write");
      expect_idx(1, "R5 write run 2");
      expect_idx(0, "R5 back to read");
      run(5);
      drain("R5 all issued");

      // R6: priority-mapped class with short limit overrides order
      do_reset();
      cfg_pri_cls = 8'h80;
      cfg_lat1 = 5'd2;
      enq(1, 1, 0, 1);
      enq(1, 2, 7, 2);
      enq(1, 3, 0, 3);
      idle(3);
      expect_idx(1, "R6 expired class-1 command first");
      expect_idx(0, "R6 then normal order");
      expect_idx(0, "R6 last");
      run(3);
      drain("R6 all issued");

      // R7: master-ID match with mask overrides priority map
      do_reset();
      cfg_pri_cls = 8'hFF;
      cfg_lat1 = 5'd2;
      cfg_mid_en = 1'b1;
      cfg_mid_match = 4'h2;
      cfg_mid_mask = 4'hE;
      cfg_mid_cls = 1'b0;
      enq(1, 2, 0, 1);
      enq(1, 3, 0, 2);
      enq(1, 5, 7, 3);
      idle(3);
      expect_idx(2, "R7 only unmatched master expires");
      expect_idx(0, "R7 matched masters normal");
      expect_idx(0, "R7 last");
      run(3);
      drain("R7 all issued");

      // R8: expired oldest wins over priority
      do_reset();
      cfg_lat0 = 5'd2;
      cfg_lat1 = 5'd2;
      enq(1, 1, 6, 1);
      enq(1, 2, 0, 2);
      enq(1, 3, 3, 3);
      idle(3);
      expect_idx(0, "R8 expired oldest first");
      expect_idx(0, "R8 expired oldest again");
      expect_idx(0, "R8 last");
      run(3);
      drain("R8 all issued");

      // R9: several expired, oldest not expired
      do_reset();
      cfg_pri_cls = 8'h24;
      cfg_lat1 = 5'd2;
      enq(1, 1, 0, 1);
      enq(1, 2, 5, 2);
      enq(1, 3, 2, 3);
      idle(3);
      expect_idx(2, "R9 best-priority expired");
      expect_idx(1, "R9 other expired");
      expect_idx(0, "R9 unexpired last");
      run(3);
      drain("R9 all issued");

      // R10: age saturates rather than wrapping
      do_reset();
      enq(1, 1, 7, 1);
      enq(1, 2, 0, 2);
      idle(40);
      expect_idx(0, "R10 saturated age keeps oldest expired");
      expect_idx(0, "R10 last");
      run(2);
      drain("R10 all issued");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule